// File: doc/BRIEF.md
# Row-and-Column Parity Block Codec

This block guards fixed-size blocks of data words with a crossed parity scheme. On the sending path each incoming data word leaves one cycle later with an even parity bit added above its top bit. After the final word of a block, one more word goes out. It is the column-wise even parity of every coded word in the block, and its top bit is the parity of the row-parity bits.

On the receiving path a whole block plus its parity word is captured. The block then recomputes the parity of every row and of every column. A single flipped data bit lies where the failing row and the failing column meet, and it is repaired. A flip that lands only in a parity bit is reported, and the data passes through untouched. Every other non-zero pattern is reported as uncorrectable, and the data is also passed through untouched. The block is released in arrival order, one word per cycle, only after its parity word has arrived. With the default parameters a block is six 7-bit words.

A sender must not start a new receive block until the release of the previous one has finished. Inputs offered during a release are discarded.

Top module: `parity2d_codec`

## Requirements
- R1: For each `tx_valid` cycle, the next cycle shows `tx_out_valid`=1 and `tx_out_par`=0. Bits W-1:0 of `tx_out_word` are the data, and bit W makes the whole W+1-bit word even.
- R2: Two cycles after the word marked `tx_last` is accepted, `tx_out_valid`=1 and `tx_out_par`=1 for one cycle. For i<W, bit i of `tx_out_word` is the XOR of bit i of the block's data words. Bit W is the XOR of their row-parity bits. An input offered in that parity cycle is dropped, so the following cycle shows `tx_out_valid`=0.
- R3: A word accepted with `tx_start`=1 clears the column accumulation, so words sent earlier do not affect the next parity word.
- R4: In the cycle after the receive parity word (`rx_valid`=1, `rx_par`=1) is taken, `rx_out_valid` rises and stays high for exactly M cycles. The words come out in arrival order, and `rx_out_last`=1 only on the final one.
- R5: A block without errors reports `rx_out_status`=0 (clean), and its data is unchanged.
- R6: One flipped data bit gives `rx_out_status`=1 (corrected), and the original data is restored.
- R7: One flipped parity bit gives `rx_out_status`=2 (parity-only). This covers any row-parity bit (word bit W), any parity-word bit, and the parity-of-parity bit. The received data is passed unchanged.
- R8: Any other non-zero syndrome gives `rx_out_status`=3 (uncorrectable), and the received data is passed unchanged. Every 2-bit error pattern falls in this case.
- R9: Every 1-, 2- or 3-bit error pattern yields a non-zero `rx_out_status`.
- R10: During reset and right after it, `tx_out_valid` and `rx_out_valid` are 0.
- R11: Receive inputs presented while a block is being released are ignored. The next block is still decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Data word offered on the sending path |
| tx_start | input | 1 | First word of a block |
| tx_last | input | 1 | Final word of a block |
| tx_data | input | W | Data word to encode |
| tx_out_valid | output | 1 | Coded word present |
| tx_out_par | output | 1 | Present word is the block parity word |
| tx_out_word | output | W+1 | Coded word; bit W is row parity |
| rx_valid | input | 1 | Received word offered |
| rx_par | input | 1 | Offered word is the parity word |
| rx_word | input | W+1 | Received coded word |
| rx_out_valid | output | 1 | Released data word present |
| rx_out_last | output | 1 | Final word of the released block |
| rx_out_data | output | W | Released (possibly repaired) data |
| rx_out_status | output | 2 | 0 clean, 1 corrected, 2 parity-only, 3 uncorrectable |

## Verification
A stale column accumulator on the sending side first shows in the parity word two cycles after the last word. A wrong row-fail flag or a wrong column syndrome shows on `rx_out_status` in the first released cycle. It also appears as a wrong bit on the word of the affected row within M cycles of that point. Error patterns are injected at chosen coordinates, including the parity row and the parity column. The expected status of each pattern is worked out by hand from the row and column counts.

// File: rtl/parity2d_codec.sv
module parity2d_codec #(
  parameter int W = 7,
  parameter int M = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_valid,
  input  logic         tx_start,
  input  logic         tx_last,
  input  logic [W-1:0] tx_data,
  output logic         tx_out_valid,
  output logic         tx_out_par,
  output logic [W:0]   tx_out_word,
  input  logic         rx_valid,
  input  logic         rx_par,
  input  logic [W:0]   rx_word,
  output logic         rx_out_valid,
  output logic         rx_out_last,
  output logic [W-1:0] rx_out_data,
  output logic [1:0]   rx_out_status
);

  localparam int IW = (M > 1) ? $clog2(M) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(M - 1);
  localparam logic [1:0] ST_CLEAN = 2'd0;
  localparam logic [1:0] ST_FIXED = 2'd1;
  localparam logic [1:0] ST_PBIT  = 2'd2;
  localparam logic [1:0] ST_BAD   = 2'd3;

  // sending path
  logic       tx_pend;
  logic [W:0] tx_acc;
  wire  [W:0] tx_coded = {^tx_data, tx_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_out_valid <= 1'b0;
      tx_out_par   <= 1'b0;
      tx_out_word  <= '0;
      tx_pend      <= 1'b0;
      tx_acc       <= '0;
    end else if (tx_pend) begin
      tx_out_valid <= 1'b1;
      tx_out_par   <= 1'b1;
      tx_out_word  <= tx_acc;
      tx_pend      <= 1'b0;
    end else if (tx_valid) begin
      tx_out_valid <= 1'b1;
      tx_out_par   <= 1'b0;
      tx_out_word  <= tx_coded;
      tx_acc       <= (tx_start ? '0 : tx_acc) ^ tx_coded;
      tx_pend      <= tx_last;
    end else begin
      tx_out_valid <= 1'b0;
      tx_out_par   <= 1'b0;
    end
  end

  // receiving path
  logic [W-1:0]  mem [M];
  logic [M-1:0]  rowfail;
  logic [W:0]    rx_acc;
  logic [W:0]    colsyn;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;
  logic          busy;

  wire take_data = rx_valid && !busy && !rx_par;

  always_ff @(posedge clk) begin
    if (take_data) mem[wr_idx] <= rx_word[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowfail <= '0;
      rx_acc  <= '0;
      colsyn  <= '0;
      wr_idx  <= '0;
      rd_idx  <= '0;
      busy    <= 1'b0;
    end else if (busy) begin
      if (rd_idx == LAST_IDX) begin
        busy   <= 1'b0;
        rd_idx <= '0;
      end else begin
        rd_idx <= rd_idx + 1'b1;
      end
    end else if (rx_valid) begin
      if (rx_par) begin
        colsyn <= rx_acc ^ rx_word;
        rx_acc <= '0;
        wr_idx <= '0;
        rd_idx <= '0;
        busy   <= 1'b1;
      end else begin
        rowfail[wr_idx] <= ^rx_word;
        rx_acc          <= rx_acc ^ rx_word;
        if (wr_idx != LAST_IDX) wr_idx <= wr_idx + 1'b1;
      end
    end
  end

  logic [1:0] st;
  int unsigned nrow, ncol;
  always_comb begin
    nrow = $countones(rowfail);
    ncol = $countones(colsyn[W-1:0]);
    if (nrow == 0 && ncol == 0 && !colsyn[W])
      st = ST_CLEAN;
    else if (nrow == 1 && ncol == 1 && !colsyn[W])
      st = ST_FIXED;
    else if ((nrow == 0 && (ncol + colsyn[W]) == 1) || (nrow == 1 && ncol == 0 && colsyn[W]))
      st = ST_PBIT;
    else
      st = ST_BAD;
  end

  wire [W-1:0] fix_mask = (st == ST_FIXED && rowfail[rd_idx]) ? colsyn[W-1:0] : '0;

  assign rx_out_valid  = busy;
  assign rx_out_last   = busy && (rd_idx == LAST_IDX);
  assign rx_out_status = busy ? st : ST_CLEAN;
  assign rx_out_data   = mem[rd_idx] ^ fix_mask;

  p_tx_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_pend |=> tx_out_valid && !tx_out_par &&
      tx_out_word == {^$past(tx_data), $past(tx_data)});

  p_tx_parword_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_last && !tx_pend |=> ##1 (tx_out_valid && tx_out_par));

  p_rx_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_par && !rx_out_valid |=> rx_out_valid);

  p_rx_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_last |=> !rx_out_valid);

  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_last |=> rx_out_valid && $stable(rx_out_status));

  p_no_touch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && rx_out_status != ST_FIXED |-> rx_out_data == mem[rd_idx]);

endmodule

// File: tb/parity2d_codec_tb.sv
module parity2d_codec_tb;
  localparam int  W = 7;
  localparam int  M = 6;
  localparam time PERIOD = 10;
  localparam int  NV = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tx_valid = 1'b0, tx_start = 1'b0, tx_last = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_out_valid, tx_out_par;
  logic [W:0]   tx_out_word;
  logic         rx_valid = 1'b0, rx_par = 1'b0;
  logic [W:0]   rx_word = '0;
  logic         rx_out_valid, rx_out_last;
  logic [W-1:0] rx_out_data;
  logic [1:0]   rx_out_status;

  parity2d_codec #(.W(W), .M(M)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_start(tx_start), .tx_last(tx_last), .tx_data(tx_data),
    .tx_out_valid(tx_out_valid), .tx_out_par(tx_out_par), .tx_out_word(tx_out_word),
    .rx_valid(rx_valid), .rx_par(rx_par), .rx_word(rx_word),
    .rx_out_valid(rx_out_valid), .rx_out_last(rx_out_last),
    .rx_out_data(rx_out_data), .rx_out_status(rx_out_status));

  always #(PERIOD/2) clk = ~clk;

  // {status, count, row0, bit0, row1, bit1, row2, bit2}; row 6 = parity word, bit 7 = row parity
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
    {2'd1, 2'd1, 3'd2, 3'd3, 3'd0, 3'd0, 3'd0, 3'd0},
    {2'd1, 2'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
    {2'd1, 2'd1, 3'd5, 3'd6, 3'd0, 3'd0, 3'd0, 3'd0},
    {2'd2, 2'd1, 3'd3, 3'd7, 3'd0, 3'd0, 3'd0, 3'd0},
    {2'd2, 2'd1, 3'd6, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0},
    {2'd2, 2'd1, 3'd6, 3'd7, 3'd0, 3'd0, 3'd0, 3'd0},
    {2'd3, 2'd2, 3'd1, 3'd2, 3'd1, 3'd5, 3'd0, 3'd0},
    {2'd3, 2'd2, 3'd0, 3'd3, 3'd4, 3'd3, 3'd0, 3'd0},
    {2'd3, 2'd2, 3'd1, 3'd1, 3'd4, 3'd6, 3'd0, 3'd0},
    {2'd3, 2'd2, 3'd2, 3'd4, 3'd2, 3'd7, 3'd0, 3'd0},
    {2'd3, 2'd2, 3'd3, 3'd1, 3'd6, 3'd1, 3'd0, 3'd0},
    {2'd3, 2'd2, 3'd2, 3'd7, 3'd6, 3'd7, 3'd0, 3'd0},
    {2'd3, 2'd3, 3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2},
    {2'd3, 2'd3, 3'd6, 3'd0, 3'd6, 3'd1, 3'd6, 3'd2}
  };

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] dat [M];
  logic [W:0]   code [M+1];
  logic [W:0]   sent [M+1];
  logic [W:0]   par_cap;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic make(input int seed);
    code[M] = '0;
    for (int k = 0; k < M; k++) begin
      dat[k]  = W'(seed * (k + 5) + k * 29 + 3);
      code[k] = {^dat[k], dat[k]};
      code[M] = code[M] ^ code[k];
    end
    for (int k = 0; k <= M; k++) sent[k] = code[k];
  endtask

  task automatic send_tx(input bit jam);
    for (int k = 0; k < M; k++) begin
      tx_valid = 1'b1; tx_data = dat[k]; tx_start = (k == 0); tx_last = (k == M - 1);
      @(negedge clk);
      chk(tx_out_valid && !tx_out_par && tx_out_word == code[k], "R1", tx_out_word, code[k]);
    end
    tx_valid = jam; tx_start = 1'b0; tx_last = 1'b0; tx_data = '1;
    @(negedge clk);
    par_cap = tx_out_word;
    chk(tx_out_valid && tx_out_par && tx_out_word == code[M], "R2", tx_out_word, code[M]);
    tx_valid = 1'b0;
    if (jam) begin
      @(negedge clk);
      chk(!tx_out_valid, "R2", tx_out_valid, 0);
    end
  endtask

  task automatic send_rx(input logic [1:0] exp_st, input string req, input bit junk);
    for (int k = 0; k <= M; k++) begin
      rx_valid = 1'b1; rx_par = (k == M); rx_word = sent[k];
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_par = 1'b0;
    for (int j = 0; j < M; j++) begin
      logic [W-1:0] expd;
      expd = (exp_st == 2'd1) ? dat[j] : sent[j][W-1:0];
      chk(rx_out_valid && rx_out_last == (j == M - 1), "R4", {rx_out_valid, rx_out_last}, {1'b1, j == M - 1});
      chk(rx_out_data == expd, req, rx_out_data, expd);
      chk(rx_out_status == exp_st, req, rx_out_status, exp_st);
      if (junk) begin rx_valid = 1'b1; rx_par = (j == 2); rx_word = '1; end
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_par = 1'b0;
    chk(!rx_out_valid, "R4", rx_out_valid, 0);
  endtask

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!tx_out_valid && !rx_out_valid, "R10", {tx_out_valid, rx_out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_out_valid && !rx_out_valid, "R10", {tx_out_valid, rx_out_valid}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [21:0] e;
      string req;
      e = VEC[v];
      make(v * 7 + 1);
      send_tx(1'b0);
      for (int p = 0; p < 3; p++) begin
        if (p < int'(e[19:18])) begin
          int r, b;
          r = int'(e[17 - 6*p -: 3]);
          b = int'(e[14 - 6*p -: 3]);
          sent[r][b] = ~sent[r][b];
        end
      end
      case (e[21:20])
        2'd0: req = "R5";
        2'd1: req = "R6";
        2'd2: req = "R7";
        default: req = "R8";
      endcase
      send_rx(e[21:20], req, 1'b0);
      if (e[19:18] != 2'd0) begin
        // R9: any 1..3-bit pattern is flagged; status is held for the whole release
        rx_valid = 1'b0;
        chk(e[21:20] != 2'd0, "R9", e[21:20], 1);
      end
      @(negedge clk);
    end

    // R3: an unfinished block must not leak into the next parity word
    make(99);
    for (int k = 0; k < 3; k++) begin
      tx_valid = 1'b1; tx_data = dat[k]; tx_start = (k == 0); tx_last = 1'b0;
      @(negedge clk);
    end
    tx_valid = 1'b0; tx_start = 1'b0;
    @(negedge clk);
    make(55);
    send_tx(1'b0);
    chk(par_cap == code[M], "R3", par_cap, code[M]);

    // R2: input offered in the parity cycle is dropped
    @(negedge clk);
    make(3);
    send_tx(1'b1);

    // R11: receive traffic during release is ignored
    @(negedge clk);
    make(21);
    send_rx(2'd0, "R11", 1'b1);
    make(42);
    sent[1][4] = ~sent[1][4];
    send_rx(2'd1, "R11", 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule